// File: doc/BRIEF.md
# Prioritized Interrupt Entry Controller

This block decides when a processor core leaves its instruction stream to take an interrupt, and it carries out the first part of that entry. A 3-bit request level comes from outside and is resynchronized. That level is compared with the 3-bit priority mask held in the core's status word. The top level, 7, follows its own rule: it is taken on a rising transition even when the mask is 7. A decision is made only when the core signals an instruction boundary. Until then, a request that qualifies simply waits.

Once a request is accepted, the block captures the incoming status word unchanged. It also builds the replacement status word: supervisor set, trace cleared, and the mask raised to the accepted level. It then opens an acknowledge cycle that presents the accepted level on a 3-bit address output and waits for the responder. The responder may supply an 8-bit vector, ask for an autovector, or signal a bus error. The resulting vector number is registered. A single-cycle completion strobe then tells the core that the saved word, the new word and the vector are ready for the stacking and table-fetch steps that follow.

Top module: `irq_entry_ctl`

## Requirements
- R1: After reset, ack_cyc, ack_lvl and entry_done are 0, and vec_num, sr_saved and sr_new are all zero.
- R2: A request at level 1 to 6 is accepted at a boundary only when it is strictly greater than the mask in sr_in bits 10:8. A request at or below the mask causes no acknowledge cycle and stays pending: it is taken at a later boundary once the mask has dropped below it.
- R3: When the request level rises from a lower value to 7, a level-7 request is latched regardless of the mask. It is accepted as level 7 at the next boundary, even if the request has fallen again by then.
- R4: If the request stays at 7 after a level-7 acceptance and the mask is 7, no further acknowledge cycle starts. Only a new rise to 7 re-arms the latch.
- R5: With the request held at 7, a mask below 7 at a boundary leads to acceptance at level 7.
- R6: Without boundary high, no acknowledge cycle starts, whatever the request level. While an acknowledge cycle is open, boundary is ignored.
- R7: sr_saved equals sr_in at the accepting boundary. sr_new equals that word with bit 13 (supervisor) set, bit 15 (trace) cleared, bits 10:8 set to the accepted level, and every other bit unchanged.
- R8: ack_cyc goes high in the cycle after the accepting boundary and stays high until a response arrives. Meanwhile ack_lvl shows the accepted level and does not change.
- R9: The vector number depends on the response. A bus error (ack_berr) gives 24, the spurious vector. An autovector request (ack_auto) gives 24 plus the level. A device response (ack_vld) gives ack_vec. When several arrive together, bus error wins over autovector, which wins over the device vector.
- R10: entry_done is high for exactly one cycle, the cycle after the response, with vec_num, sr_saved and sr_new valid. At that point ack_cyc is already low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_lvl | input | 3 | Encoded interrupt request level, 0 = none |
| boundary | input | 1 | High in a cycle that is an instruction boundary |
| sr_in | input | 16 | Current status word (mask in bits 10:8) |
| ack_vld | input | 1 | Responder supplies a vector on ack_vec |
| ack_vec | input | 8 | Vector number from the responder |
| ack_auto | input | 1 | Responder requests an autovector |
| ack_berr | input | 1 | Bus error during the acknowledge cycle |
| ack_cyc | output | 1 | Acknowledge cycle in progress |
| ack_lvl | output | 3 | Accepted level presented on the address bus |
| sr_saved | output | 16 | Copy of the status word at acceptance |
| sr_new | output | 16 | Status word to load on entry |
| vec_num | output | 8 | Resolved vector number |
| entry_done | output | 1 | One-cycle strobe: entry outputs valid |

## Verification
Some properties are checked on every cycle by the assertions. Each acceptance lies above the mask or is a level-7 request. A latched level-7 request is never skipped at a boundary. An acknowledge cycle never opens without a boundary, and its level stays stable. The completion strobe lasts one cycle, and the fields of the new status word match the acknowledged level. Several behaviours need the bench's ordered scenarios because they depend on history: a pending request taken after the mask drops, a short level-7 pulse remembered until the next boundary, no re-trigger while 7 is held, re-arming after a fresh rise, and the priority among simultaneous responses.

// File: rtl/irqe_pkg.sv
package irqe_pkg;
   typedef enum logic [0:0] {
      SEQ_IDLE = 1'b0,
      SEQ_ACK  = 1'b1
   } seq_state_t;
endpackage

// File: rtl/irqe_sync.sv
module irqe_sync #(
   parameter int W      = 3,
   parameter int STAGES = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 0 || STAGES > 4) begin : g_bad_stages
      $error("irqe_sync: STAGES must be 0..4");
   end

   if (STAGES == 0) begin : g_pass
      assign q = d;
   end else begin : g_pipe
      logic [W-1:0] pipe [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
         end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
         end
      end
      assign q = pipe[STAGES-1];
   end
endmodule

// File: rtl/irqe_arbiter.sv
module irqe_arbiter #(
   parameter int LVL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LVL_W-1:0] req_s,
   input  logic [LVL_W-1:0] mask,
   input  logic             boundary,
   input  logic             idle,
   output logic             accept,
   output logic [LVL_W-1:0] acc_lvl
);
   localparam logic [LVL_W-1:0] TOP = {LVL_W{1'b1}};

   logic [LVL_W-1:0] prev_lvl;
   logic             nmi_pend;
   logic             top_rise;
   logic             cmp_hit;
   logic             top_hit;

   assign top_rise = (req_s == TOP) && (prev_lvl != TOP);
   assign cmp_hit  = req_s > mask;
   assign top_hit  = nmi_pend || top_rise;
   assign accept   = boundary && idle && (top_hit || cmp_hit);
   assign acc_lvl  = top_hit ? TOP : req_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_lvl <= '0;
         nmi_pend <= 1'b0;
      end else begin
         prev_lvl <= req_s;
         if (accept && acc_lvl == TOP) nmi_pend <= 1'b0;
         else if (top_rise)            nmi_pend <= 1'b1;
      end
   end

   // R2
   above_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept |-> ((acc_lvl > mask) || (acc_lvl == TOP)));

   // R3
   nmi_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (nmi_pend && boundary && idle) |-> (accept && acc_lvl == TOP));
endmodule

// File: rtl/irqe_ack_seq.sv
module irqe_ack_seq
   import irqe_pkg::*;
#(
   parameter int LVL_W     = 3,
   parameter int SR_W      = 16,
   parameter int VEC_W     = 8,
   parameter int MASK_LSB  = 8,
   parameter int S_BIT     = 13,
   parameter int T_BIT     = 15,
   parameter int AUTO_BASE = 24,
   parameter int SPUR_VEC  = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             accept,
   input  logic [LVL_W-1:0] acc_lvl,
   input  logic [SR_W-1:0]  sr_in,
   input  logic             ack_vld,
   input  logic [VEC_W-1:0] ack_vec,
   input  logic             ack_auto,
   input  logic             ack_berr,
   output logic             idle,
   output logic             ack_cyc,
   output logic [LVL_W-1:0] ack_lvl,
   output logic [SR_W-1:0]  sr_saved,
   output logic [SR_W-1:0]  sr_new,
   output logic [VEC_W-1:0] vec_num,
   output logic             entry_done
);
   localparam logic [VEC_W-1:0] AUTO_V = AUTO_BASE[VEC_W-1:0];
   localparam logic [VEC_W-1:0] SPUR_V = SPUR_VEC[VEC_W-1:0];

   seq_state_t       state;
   logic [LVL_W-1:0] lvl_q;
   logic [SR_W-1:0]  sr_nxt;
   logic             rsp_any;
   logic [VEC_W-1:0] vec_pick;

   always_comb begin
      sr_nxt                     = sr_in;
      sr_nxt[T_BIT]              = 1'b0;
      sr_nxt[S_BIT]              = 1'b1;
      sr_nxt[MASK_LSB +: LVL_W]  = acc_lvl;
   end

   assign rsp_any = ack_berr || ack_auto || ack_vld;

   always_comb begin
      if (ack_berr)      vec_pick = SPUR_V;
      else if (ack_auto) vec_pick = AUTO_V + VEC_W'(lvl_q);
      else               vec_pick = ack_vec;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= SEQ_IDLE;
         lvl_q      <= '0;
         sr_saved   <= '0;
         sr_new     <= '0;
         vec_num    <= '0;
         entry_done <= 1'b0;
      end else begin
         entry_done <= 1'b0;
         case (state)
            SEQ_IDLE: if (accept) begin
               state    <= SEQ_ACK;
               lvl_q    <= acc_lvl;
               sr_saved <= sr_in;
               sr_new   <= sr_nxt;
            end
            SEQ_ACK: if (rsp_any) begin
               state      <= SEQ_IDLE;
               vec_num    <= vec_pick;
               entry_done <= 1'b1;
            end
            default: state <= SEQ_IDLE;
         endcase
      end
   end

   assign idle    = (state == SEQ_IDLE);
   assign ack_cyc = (state == SEQ_ACK);
   assign ack_lvl = ack_cyc ? lvl_q : '0;

   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      entry_done |=> !entry_done);

   // R8
   ack_lvl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_cyc && $past(ack_cyc)) |-> $stable(ack_lvl));

   // R9
   spurious_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (entry_done && $past(ack_berr)) |-> (vec_num == SPUR_V));
endmodule

// File: rtl/irq_entry_ctl.sv
module irq_entry_ctl #(
   parameter int LVL_W       = 3,
   parameter int SR_W        = 16,
   parameter int VEC_W       = 8,
   parameter int MASK_LSB    = 8,
   parameter int S_BIT       = 13,
   parameter int T_BIT       = 15,
   parameter int AUTO_BASE   = 24,
   parameter int SPUR_VEC    = 24,
   parameter int SYNC_STAGES = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LVL_W-1:0] req_lvl,
   input  logic             boundary,
   input  logic [SR_W-1:0]  sr_in,
   input  logic             ack_vld,
   input  logic [VEC_W-1:0] ack_vec,
   input  logic             ack_auto,
   input  logic             ack_berr,
   output logic             ack_cyc,
   output logic [LVL_W-1:0] ack_lvl,
   output logic [SR_W-1:0]  sr_saved,
   output logic [SR_W-1:0]  sr_new,
   output logic [VEC_W-1:0] vec_num,
   output logic             entry_done
);
   localparam int TOP_I = (1 << LVL_W) - 1;

   if (MASK_LSB + LVL_W > SR_W) begin : g_bad_mask
      $error("irq_entry_ctl: mask field outside status word");
   end
   if (S_BIT >= SR_W || T_BIT >= SR_W || S_BIT == T_BIT) begin : g_bad_bits
      $error("irq_entry_ctl: bad supervisor/trace bit positions");
   end
   if ((S_BIT >= MASK_LSB && S_BIT < MASK_LSB + LVL_W) ||
       (T_BIT >= MASK_LSB && T_BIT < MASK_LSB + LVL_W)) begin : g_bad_overlap
      $error("irq_entry_ctl: status bits overlap mask field");
   end
   if (AUTO_BASE + TOP_I >= (1 << VEC_W) || SPUR_VEC >= (1 << VEC_W)) begin : g_bad_vec
      $error("irq_entry_ctl: vector numbers exceed VEC_W");
   end

   logic [LVL_W-1:0] req_s;
   logic             accept;
   logic [LVL_W-1:0] acc_lvl;
   logic             idle;

   irqe_sync #(.W(LVL_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(req_lvl), .q(req_s)
   );

   irqe_arbiter #(.LVL_W(LVL_W)) u_arb (
      .clk(clk), .rst_n(rst_n), .req_s(req_s),
      .mask(sr_in[MASK_LSB +: LVL_W]), .boundary(boundary), .idle(idle),
      .accept(accept), .acc_lvl(acc_lvl)
   );

   irqe_ack_seq #(
      .LVL_W(LVL_W), .SR_W(SR_W), .VEC_W(VEC_W), .MASK_LSB(MASK_LSB),
      .S_BIT(S_BIT), .T_BIT(T_BIT), .AUTO_BASE(AUTO_BASE), .SPUR_VEC(SPUR_VEC)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .accept(accept), .acc_lvl(acc_lvl),
      .sr_in(sr_in), .ack_vld(ack_vld), .ack_vec(ack_vec),
      .ack_auto(ack_auto), .ack_berr(ack_berr), .idle(idle),
      .ack_cyc(ack_cyc), .ack_lvl(ack_lvl), .sr_saved(sr_saved),
      .sr_new(sr_new), .vec_num(vec_num), .entry_done(entry_done)
   );

   // R6
   ack_needs_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack_cyc) |-> $past(boundary));

   // R7
   sr_new_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
      entry_done |-> (sr_new[S_BIT] && !sr_new[T_BIT] &&
                      sr_new[MASK_LSB +: LVL_W] == $past(ack_lvl)));
endmodule

// File: tb/irq_entry_ctl_tb.sv
module irq_entry_ctl_tb;
   typedef struct {
      logic [7:0]  vec;
      logic [15:0] saved;
      logic [15:0] nsr;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  req_lvl = '0;
   logic        boundary = 1'b0;
   logic [15:0] sr_in = '0;
   logic        ack_vld = 1'b0;
   logic [7:0]  ack_vec = '0;
   logic        ack_auto = 1'b0;
   logic        ack_berr = 1'b0;
   logic        ack_cyc;
   logic [2:0]  ack_lvl;
   logic [15:0] sr_saved;
   logic [15:0] sr_new;
   logic [7:0]  vec_num;
   logic        entry_done;

   int checks = 0;
   int failures = 0;
   exp_t sb_q[$];

   always #2 clk = ~clk;

   irq_entry_ctl u_dut (
      .clk(clk), .rst_n(rst_n), .req_lvl(req_lvl), .boundary(boundary),
      .sr_in(sr_in), .ack_vld(ack_vld), .ack_vec(ack_vec),
      .ack_auto(ack_auto), .ack_berr(ack_berr), .ack_cyc(ack_cyc),
      .ack_lvl(ack_lvl), .sr_saved(sr_saved), .sr_new(sr_new),
      .vec_num(vec_num), .entry_done(entry_done)
   );

   task automatic chk(input bit ok, input string tag,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] model_sr(input logic [15:0] sr, input logic [2:0] lvl);
      logic [15:0] r;
      r = sr;
      r[15] = 1'b0;
      r[13] = 1'b1;
      r[10:8] = lvl;
      return r;
   endfunction

   // monitor: pops the scoreboard on every completion strobe
   always @(negedge clk) begin
      if (rst_n && entry_done) begin
         if (sb_q.size() == 0) begin
            chk(1'b0, "R10 unexpected entry_done", 32'(vec_num), 32'hFFFF);
         end else begin
            exp_t e;
            e = sb_q.pop_front();
            chk(vec_num == e.vec, {e.tag, " R9 vector"}, 32'(vec_num), 32'(e.vec));
            chk(sr_saved == e.saved, {e.tag, " R7 saved"}, 32'(sr_saved), 32'(e.saved));
            chk(sr_new == e.nsr, {e.tag, " R7 new"}, 32'(sr_new), 32'(e.nsr));
            chk(!ack_cyc, {e.tag, " R10 ack closed"}, 32'(ack_cyc), 32'h0);
         end
      end
   end

   task automatic set_req(input logic [2:0] l);
      req_lvl = l;
      repeat (3) @(negedge clk);
   endtask

   // rsp: 0 device, 1 auto, 2 berr, 3 berr+auto, 4 auto+device
   task automatic do_entry(input logic [2:0] lvl, input logic [15:0] sr,
                           input int rsp, input logic [7:0] dv,
                           input logic [7:0] exp_vec, input int hold,
                           input string tag);
      exp_t e;
      sr_in = sr;
      boundary = 1'b1;
      @(negedge clk);
      boundary = 1'b0;
      chk(ack_cyc == 1'b1, {tag, " R8 ack open"}, 32'(ack_cyc), 32'h1);
      chk(ack_lvl == lvl, {tag, " R8 ack level"}, 32'(ack_lvl), 32'(lvl));
      for (int i = 0; i < hold; i++) begin
         boundary = 1'b1;
         @(negedge clk);
         boundary = 1'b0;
         chk(ack_cyc && ack_lvl == lvl, {tag, " R6 boundary ignored in ack"},
             32'(ack_lvl), 32'(lvl));
      end
      e.vec = exp_vec; e.saved = sr; e.nsr = model_sr(sr, lvl); e.tag = tag;
      sb_q.push_back(e);
      ack_vec  = dv;
      ack_vld  = (rsp == 0) || (rsp == 4);
      ack_auto = (rsp == 1) || (rsp == 3) || (rsp == 4);
      ack_berr = (rsp == 2) || (rsp == 3);
      @(negedge clk);
      ack_vld = 1'b0; ack_auto = 1'b0; ack_berr = 1'b0;
      @(negedge clk);
      chk(!entry_done, {tag, " R10 single pulse"}, 32'(entry_done), 32'h0);
   endtask

   task automatic no_entry(input logic [15:0] sr, input string tag);
      sr_in = sr;
      boundary = 1'b1;
      @(negedge clk);
      boundary = 1'b0;
      chk(!ack_cyc, tag, 32'(ack_cyc), 32'h0);
      @(negedge clk);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(!ack_cyc && !entry_done, "R1 idle outputs", 32'({ack_cyc, entry_done}), 32'h0);
      chk(vec_num == 8'h0 && ack_lvl == 3'h0, "R1 vector and level", 32'(vec_num), 32'h0);
      chk(sr_saved == 16'h0 && sr_new == 16'h0, "R1 status words", 32'(sr_saved), 32'h0);

      // R6: no boundary, no acknowledge
      sr_in = 16'h8000;
      set_req(3'd5);
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         chk(!ack_cyc, "R6 no boundary", 32'(ack_cyc), 32'h0);
      end
      do_entry(3'd5, 16'h8000, 1, 8'h00, 8'd29, 0, "R9 autovector lvl5");

      // R2 mask comparison and pending
      set_req(3'd3);
      no_entry(16'h0300, "R2 equal to mask");
      no_entry(16'h0500, "R2 below mask");
      do_entry(3'd3, 16'h0200, 0, 8'h40, 8'h40, 2, "R2 pending taken");

      // R9 responses and priority
      set_req(3'd6);
      do_entry(3'd6, 16'h0000, 2, 8'h55, 8'd24, 0, "R9 bus error");
      set_req(3'd1);
      do_entry(3'd1, 16'h0000, 3, 8'h55, 8'd24, 0, "R9 berr over auto");
      do_entry(3'd1, 16'h40A5, 4, 8'h77, 8'd25, 1, "R9 auto over device");

      // R3 short level-7 pulse remembered with mask 7
      set_req(3'd0);
      req_lvl = 3'd7;
      repeat (2) @(negedge clk);
      req_lvl = 3'd0;
      repeat (3) @(negedge clk);
      chk(!ack_cyc, "R3 held until boundary", 32'(ack_cyc), 32'h0);
      do_entry(3'd7, 16'h2700, 0, 8'h99, 8'h99, 0, "R3 edge ignores mask");

      // R4 held at 7 does not retrigger
      set_req(3'd7);
      do_entry(3'd7, 16'h2700, 1, 8'h00, 8'd31, 0, "R3 rise to 7");
      no_entry(16'h2700, "R4 held at 7 mask 7");
      no_entry(16'h2700, "R4 still held");

      // R5 mask lowered while request stays at 7
      do_entry(3'd7, 16'h2300, 1, 8'h00, 8'd31, 0, "R5 mask lowered");

      // R4 re-arm by new rise
      set_req(3'd0);
      set_req(3'd7);
      do_entry(3'd7, 16'h2700, 2, 8'h00, 8'd24, 0, "R4 re-armed");

      repeat (3) @(negedge clk);
      chk(sb_q.size() == 0, "R10 all entries seen", 32'(sb_q.size()), 32'h0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule